// File: doc/BRIEF.md
# Command Status Register with Overrun Counter

This block holds the command and status word of a host controller. Software issues commands by writing to it through a plain register write port. A bit written as 1 sets the matching command flag. A bit written as 0 has no effect. Several commands can therefore be posted one after another without reading the register first, and no earlier command is lost. The controller logic consumes each command and then drops that flag through a dedicated clear input.

The same word also carries a 2-bit scheduling overrun count. An overrun is detected when the end-of-frame strobe arrives while the periodic list is not yet done. On each overrun the count advances and a one-cycle pulse asks the interrupt status logic to set its overrun flag. The interrupt status register and the actions started by the commands sit outside this block.

Top module: `cmd_status_reg`

## Requirements
- R1: A write with `wr_en` high sets every command bit 0..3 whose `wr_data` bit is 1, and the new value appears on `reg_value` after the next rising clock edge. Bit 0 is controller reset, bit 1 is control list filled, bit 2 is bulk list filled and bit 3 is ownership change request.
- R2: A command bit whose `wr_data` bit is 0 during a write keeps its previous value.
- R3: `hw_clr[i]` clears command bit i at the next edge and leaves every other bit unchanged.
- R4: If a software set and `hw_clr[i]` hit bit i in the same cycle, the bit ends up set.
- R5: Bits 15..4 and 31..18 of `reg_value` always read 0, whatever is written.
- R6: When `eof_pulse` is high and `periodic_done` is low at a clock edge, the overrun count in bits 17:16 increases by one at that edge. When `periodic_done` is high, the count is unchanged.
- R7: The overrun count wraps from 3 to 0.
- R8: Software writes never change bits 17:16.
- R9: `sched_ovr_irq` is high for exactly the one cycle after an overrun edge and is low in every other cycle.
- R10: While `rst_n` is low, and right after it is released, `reg_value` is 0 and `sched_ovr_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data (1 = set) |
| hw_clr | input | 4 | Per-command clear requests from the controller |
| eof_pulse | input | 1 | End-of-frame strobe |
| periodic_done | input | 1 | Periodic list finished for this frame |
| reg_value | output | 32 | Register read value |
| sched_ovr_irq | output | 1 | One-cycle request to set the overrun interrupt status |

## Verification
The assertions take the inputs as already synchronous to `clk`. They treat `eof_pulse` as an event in the cycle where it is high, so the periodic-done level is only sampled in that cycle. The checker does not require `eof_pulse` to be a single-cycle strobe. The bench drives every input on the falling edge and keeps `hw_clr` and `wr_data` stable for whole cycles. It drives back-to-back end-of-frame cycles on purpose, to show that the pulse rule still holds for each edge.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int REG_W   = 32;
  localparam int CMD_N   = 4;
  localparam int OVR_W   = 2;
  localparam int OVR_LSB = 16;

  typedef enum logic [1:0] {
    CMD_HC_RESET = 2'd0,
    CMD_CTRL_FILL = 2'd1,
    CMD_BULK_FILL = 2'd2,
    CMD_OWN_REQ   = 2'd3
  } cmd_idx_e;

  // Next state of one command flag: a set beats a clear.
  function automatic logic cmd_next(input logic cur, input logic set_req,
                                    input logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

  // Overrun count advance, wraps naturally at the field width.
  function automatic logic [OVR_W-1:0] ovr_advance(input logic [OVR_W-1:0] cnt,
                                                   input logic hit);
    return hit ? cnt + OVR_W'(1) : cnt;
  endfunction
endpackage

// File: rtl/cmd_bit_cell.sv
module cmd_bit_cell
  import cmdstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= cmd_next(flag_q, set_req, clr_req);
  end

  assign flag = flag_q;
endmodule

// File: rtl/overrun_tracker.sv
module overrun_tracker
  import cmdstat_pkg::*;
#(
  parameter int CW = OVR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eof_pulse,
  input  logic          periodic_done,
  output logic          ovr_hit,
  output logic [CW-1:0] ovr_cnt,
  output logic          irq_pulse
);
  logic [CW-1:0] cnt_q;
  logic          irq_q;

  assign ovr_hit = eof_pulse & ~periodic_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= hit_next(cnt_q, ovr_hit);
      irq_q <= ovr_hit;
    end
  end

  function automatic logic [CW-1:0] hit_next(input logic [CW-1:0] c, input logic h);
    return h ? c + CW'(1) : c;
  endfunction

  assign ovr_cnt   = cnt_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/cmd_status_reg.sv
module cmd_status_reg
  import cmdstat_pkg::*;
#(
  parameter int DW   = REG_W,
  parameter int NCMD = CMD_N,
  parameter int CW   = OVR_W,
  parameter int CLSB = OVR_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCMD-1:0] hw_clr,
  input  logic            eof_pulse,
  input  logic            periodic_done,
  output logic [DW-1:0]   reg_value,
  output logic            sched_ovr_irq
);
  localparam int CMSB = CLSB + CW - 1;

  logic [NCMD-1:0] set_vec;
  logic [NCMD-1:0] cmd_flags;
  logic [CW-1:0]   ovr_cnt;
  logic            ovr_evt;

  assign set_vec = wr_en ? wr_data[NCMD-1:0] : '0;

  for (genvar i = 0; i < NCMD; i++) begin : g_cmd
    cmd_bit_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_vec[i]),
      .clr_req (hw_clr[i]),
      .flag    (cmd_flags[i])
    );
  end

  overrun_tracker #(.CW(CW)) u_ovr (
    .clk           (clk),
    .rst_n         (rst_n),
    .eof_pulse     (eof_pulse),
    .periodic_done (periodic_done),
    .ovr_hit       (ovr_evt),
    .ovr_cnt       (ovr_cnt),
    .irq_pulse     (sched_ovr_irq)
  );

  always_comb begin
    reg_value                = '0;
    reg_value[NCMD-1:0]      = cmd_flags;
    reg_value[CMSB:CLSB]     = ovr_cnt;
  end
endmodule

// File: rtl/cmd_status_chk.sv
module cmd_status_chk #(
  parameter int DW   = 32,
  parameter int NCMD = 4,
  parameter int CW   = 2,
  parameter int CLSB = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic [NCMD-1:0] hw_clr,
  input logic            eof_pulse,
  input logic            periodic_done,
  input logic [DW-1:0]   reg_value,
  input logic            sched_ovr_irq,
  input logic            ovr_evt
);
  localparam int CMSB = CLSB + CW - 1;
  localparam logic [DW-1:0] LIVE = {{(DW-NCMD){1'b0}}, {NCMD{1'b1}}} |
                                   ({{(DW-CW){1'b0}}, {CW{1'b1}}} << CLSB);

  logic [NCMD-1:0] sw_set;
  assign sw_set = wr_en ? wr_data[NCMD-1:0] : '0;

  // R1
  // R4
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((reg_value[NCMD-1:0] & $past(sw_set)) == $past(sw_set)));

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_clr & ~sw_set) != '0) |=> ((reg_value[NCMD-1:0] & $past(hw_clr & ~sw_set)) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set == '0 && hw_clr == '0) |=> $stable(reg_value[NCMD-1:0]));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_value & ~LIVE) == '0);

  // R6
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_pulse && !periodic_done) |=> (reg_value[CMSB:CLSB] == CW'($past(reg_value[CMSB:CLSB]) + 1)));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof_pulse && !periodic_done) |=> $stable(reg_value[CMSB:CLSB]));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> sched_ovr_irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof_pulse && !periodic_done) |=> !sched_ovr_irq);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (reg_value == '0 && !sched_ovr_irq));
endmodule

bind cmd_status_reg cmd_status_chk #(
  .DW(DW), .NCMD(NCMD), .CW(CW), .CLSB(CLSB)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .hw_clr        (hw_clr),
  .eof_pulse     (eof_pulse),
  .periodic_done (periodic_done),
  .reg_value     (reg_value),
  .sched_ovr_irq (sched_ovr_irq),
  .ovr_evt       (ovr_evt)
);

// File: tb/cmd_status_reg_test.sv
module cmd_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  hw_clr = '0;
  logic        eof_pulse = 1'b0;
  logic        periodic_done = 1'b0;
  logic [31:0] reg_value;
  logic        sched_ovr_irq;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [31:0] val;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench-side model state
  logic [3:0] m_cmd = '0;
  logic [1:0] m_cnt = '0;

  always #5 clk = ~clk;

  cmd_status_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_clr(hw_clr), .eof_pulse(eof_pulse), .periodic_done(periodic_done),
    .reg_value(reg_value), .sched_ovr_irq(sched_ovr_irq)
  );

  function automatic logic [31:0] pack(input logic [3:0] c, input logic [1:0] n);
    logic [31:0] r;
    r = 32'h0;
    r[3:0]   = c;
    r[17:16] = n;
    return r;
  endfunction

  task automatic compare(input logic [31:0] av, input logic ai,
                         input logic [31:0] ev, input logic ei, input string tag);
    checks++;
    if (av !== ev || ai !== ei) begin
      failures++;
      $display("FAIL %s: reg_value=%h irq=%b expected reg_value=%h irq=%b",
               tag, av, ai, ev, ei);
    end
  endtask

  // driver: apply one cycle of stimulus on the falling edge, push expectation
  task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] clr,
                      input logic eof, input logic pdone, input string tag);
    exp_t e;
    logic [3:0] setv;
    logic       hit;
    @(negedge clk);
    wr_en = we; wr_data = wd; hw_clr = clr; eof_pulse = eof; periodic_done = pdone;
    setv = we ? wd[3:0] : 4'h0;
    hit  = eof && !pdone;
    for (int i = 0; i < 4; i++)
      if (setv[i]) m_cmd[i] = 1'b1;
      else if (clr[i]) m_cmd[i] = 1'b0;
    if (hit) m_cnt = (m_cnt == 2'd3) ? 2'd0 : m_cnt + 2'd1;
    e.val = pack(m_cmd, m_cnt);
    e.irq = hit;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, tag);
  endtask

  // monitor: one cycle after each edge, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(reg_value, sched_ovr_irq, e.val, e.irq, e.tag);
      end
    end
  end

  initial begin
    #200000;
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state, even with stimulus present during reset
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; eof_pulse = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare(reg_value, sched_ovr_irq, 32'h0, 1'b0, "R10 in reset");
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; eof_pulse = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1 compare(reg_value, sched_ovr_irq, 32'h0, 1'b0, "R10 after release");

    // R1: individual command sets
    step(1'b1, 32'h1, 4'h0, 1'b0, 1'b0, "R1 set controller reset");
    step(1'b1, 32'h4, 4'h0, 1'b0, 1'b0, "R1 R2 set bulk, reset kept");
    step(1'b1, 32'h0, 4'h0, 1'b0, 1'b0, "R2 zero write no change");
    step(1'b1, 32'hA, 4'h0, 1'b0, 1'b0, "R1 R2 set control and ownership");
    idle("R2 hold");
    // R3: clears per bit
    step(1'b0, 32'h0, 4'h2, 1'b0, 1'b0, "R3 clear control only");
    step(1'b0, 32'h0, 4'h5, 1'b0, 1'b0, "R3 clear reset and bulk");
    // R3 with write of other bit not blocking the clear
    step(1'b1, 32'h1, 4'h8, 1'b0, 1'b0, "R3 R1 clear ownership while setting reset");
    // R4: set beats clear on same bit
    step(1'b1, 32'h6, 4'h6, 1'b0, 1'b0, "R4 set wins over clear");
    step(1'b0, 32'h6, 4'h0, 1'b0, 1'b0, "R1 no set without strobe");
    // R5, R8: reserved and count bits ignore writes
    step(1'b1, 32'hFFFF_FFF0, 4'h0, 1'b0, 1'b0, "R5 R8 reserved and count write ignored");
    step(1'b1, 32'h0003_0000, 4'h0, 1'b0, 1'b0, "R8 count write ignored");
    // R6, R9: overrun and no overrun
    step(1'b0, 32'h0, 4'h0, 1'b1, 1'b1, "R6 R9 eof with done");
    step(1'b0, 32'h0, 4'h0, 1'b1, 1'b0, "R6 R9 overrun");
    idle("R9 pulse ends");
    step(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, "R9 done low without eof");
    // R7: back-to-back overruns, wrap 3 -> 0
    step(1'b0, 32'h0, 4'h0, 1'b1, 1'b0, "R6 to 2");
    step(1'b0, 32'h0, 4'h0, 1'b1, 1'b0, "R6 to 3");
    step(1'b1, 32'h0003_0008, 4'h0, 1'b1, 1'b0, "R7 R8 wrap to 0 during write");
    step(1'b0, 32'h0, 4'hF, 1'b1, 1'b0, "R6 R3 after wrap, clear all");
    idle("R9 final quiet");
    idle("R2 final hold");

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule